// File: doc/BRIEF.md
# Sprite Line Selector and Pixel Generator

This block keeps the sprite descriptor table of a tile-based video pipeline and turns it into one sprite pixel per screen position. The table holds 64 sprites of four bytes each and is filled by a processor through a byte-wide write port. Once per scanline the host pulses a start strobe with the number of the line about to be drawn. The block scans the table in index order and keeps up to eight sprites whose vertical span includes that line. It fetches two pattern bit-planes for each kept sprite over a pattern-memory read port. When the preparation ends, it switches that set in as the active set.

While a new set is being prepared, the active set keeps serving pixel requests. For each horizontal position the block returns a 5-bit sprite colour index, an opaque flag and the background-priority bit of the frontmost sprite that is not transparent. Mixing with the background is left to the consumer.

Top module: `sprite_renderer`

## Requirements
- R1: A write at byte address A stores the data into field A[1:0] of sprite A[7:2]. Field 0 is the top row Y, field 1 the tile number, field 2 the attribute byte and field 3 the left column X.
- R2: A sprite takes part in line L when L − Y, computed without wrap-around, lies in 0..7.
- R3: At most 8 sprites take part in a line: the lowest-indexed ones that pass R2. Sprites with higher indices are ignored for that line.
- R4: A sprite covers position P when P − X, computed without wrap-around, lies in 0..7. Offset 0 takes pattern bit 7 and offset 7 takes bit 0.
- R5: A plane byte is read at pattern address {tile[7:0], plane, row[2:0]}. Plane 0 gives bit 0 of the 2-bit pixel value and plane 1 gives bit 1. Each read returns its data one clock after the address.
- R6: With attribute bit 7 set, the row fetched is 7 − (L − Y) instead of L − Y.
- R7: With attribute bit 6 set, both plane bytes are bit-reversed, so offset 0 takes bit 0.
- R8: A pixel value of 0 is transparent. Among the sprites kept for the line, the lowest-indexed sprite with a non-zero value at P supplies the output.
- R9: For a winning pixel, the colour is {1, attr[1:0], value}, opaque is 1 and behind equals attr[5]. With no winner, all three outputs are 0.
- R10: The outputs for position P appear on the clock edge after P is presented.
- R11: After reset, no sprite is active. A line's set replaces the previous set only when its preparation is complete, and until then pixels come from the previous set.
- R12: A start strobe during preparation abandons that preparation and begins a fresh scan for the newly given line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oam_we | input | 1 | Table byte write enable |
| oam_addr | input | 8 | Table byte address |
| oam_wdata | input | 8 | Table write data |
| line_start | input | 1 | Start preparing the set for line_y |
| line_y | input | 8 | Line to prepare |
| pix_x | input | 8 | Horizontal position to render |
| pat_addr | output | 12 | Pattern memory byte address |
| pat_rdata | input | 8 | Pattern memory data, one clock after address |
| spr_color | output | 5 | Sprite colour index |
| spr_opaque | output | 1 | Sprite pixel present |
| spr_behind | output | 1 | Winning sprite sits behind background |

## Verification
Pixel generation from the active set and preparation of the next line's set run in the same cycles. The bench starts a new line and then keeps requesting pixels during the whole scan window. Each of those pixels must match the reference for the previous line, and after the swap the pixels must match the new line. A restart strobe that lands in the middle of a scan is also issued, and the result is judged against the reference for the second line only.

// File: rtl/sprite_pkg.sv
package sprite_pkg;

    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_SCAN  = 2'd1,
        EV_FETCH = 2'd2
    } ev_state_t;

    // One table record as read out in a single cycle
    typedef struct packed {
        logic [7:0] y;
        logic [7:0] tile;
        logic [7:0] attr;
        logic [7:0] x;
    } spr_rec_t;

    // Everything the pixel stage needs about one selected sprite
    typedef struct packed {
        logic [7:0] x;
        logic [1:0] pal;
        logic       behind;
        logic [7:0] lo;
        logic [7:0] hi;
    } slot_t;

    localparam int ATTR_VFLIP  = 7;
    localparam int ATTR_HFLIP  = 6;
    localparam int ATTR_BEHIND = 5;

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

endpackage

// File: rtl/sprite_table.sv
module sprite_table #(
    parameter int NUM_SPR = 64
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [$clog2(NUM_SPR*4)-1:0] waddr,
    input  logic [7:0]                   wdata,
    input  logic [$clog2(NUM_SPR)-1:0]   rd_idx,
    output sprite_pkg::spr_rec_t         rd_rec
);
    localparam int BYTES = NUM_SPR * 4;

    logic [7:0] mem_q [BYTES];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Field order inside a record: Y, tile, attribute, X
    always_comb begin
        rd_rec.y    = mem_q[{rd_idx, 2'd0}];
        rd_rec.tile = mem_q[{rd_idx, 2'd1}];
        rd_rec.attr = mem_q[{rd_idx, 2'd2}];
        rd_rec.x    = mem_q[{rd_idx, 2'd3}];
    end

endmodule

// File: rtl/sprite_eval.sv
module sprite_eval
    import sprite_pkg::*;
#(
    parameter int NUM_SPR = 64,
    parameter int SLOTS   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         line_start,
    input  logic [7:0]                   line_y,
    input  spr_rec_t                     rec,
    input  logic [7:0]                   pat_rdata,
    output logic [$clog2(NUM_SPR)-1:0]   rd_idx,
    output logic [11:0]                  pat_addr,
    output logic                         swap,
    output slot_t [SLOTS-1:0]            new_slots,
    output logic [$clog2(SLOTS+1)-1:0]   new_cnt
);
    localparam int IW = $clog2(NUM_SPR);
    localparam int SW = $clog2(SLOTS);
    localparam int CW = $clog2(SLOTS+1);
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_SPR - 1);

    typedef struct packed {
        ev_state_t                st;
        logic [7:0]               line;
        logic [IW-1:0]            idx;
        logic [CW-1:0]            cnt;
        logic [SW-1:0]            fslot;
        logic [1:0]               ph;
        logic                     swap;
        slot_t [SLOTS-1:0]        slots;
        logic [SLOTS-1:0][7:0]    tile;
        logic [SLOTS-1:0][2:0]    row;
        logic [SLOTS-1:0]         hflip;
    } ev_t;

    ev_t q, d;

    logic [8:0] dy;
    logic       covers;
    logic [7:0] cap;

    assign dy     = {1'b0, q.line} - {1'b0, rec.y};
    assign covers = (dy < 9'd8);
    assign cap    = q.hflip[q.fslot] ? rev8(pat_rdata) : pat_rdata;

    always_comb begin
        d      = q;
        d.swap = 1'b0;
        case (q.st)
            EV_SCAN: begin
                if (covers && (q.cnt < CW'(SLOTS))) begin
                    d.slots[q.cnt[SW-1:0]].x      = rec.x;
                    d.slots[q.cnt[SW-1:0]].pal    = rec.attr[1:0];
                    d.slots[q.cnt[SW-1:0]].behind = rec.attr[ATTR_BEHIND];
                    d.slots[q.cnt[SW-1:0]].lo     = 8'h00;
                    d.slots[q.cnt[SW-1:0]].hi     = 8'h00;
                    d.tile[q.cnt[SW-1:0]]         = rec.tile;
                    d.row[q.cnt[SW-1:0]]          = dy[2:0] ^ {3{rec.attr[ATTR_VFLIP]}};
                    d.hflip[q.cnt[SW-1:0]]        = rec.attr[ATTR_HFLIP];
                    d.cnt                         = q.cnt + CW'(1);
                end
                d.idx = q.idx + IW'(1);
                if (q.idx == LAST_IDX) begin
                    d.fslot = '0;
                    d.ph    = 2'd0;
                    if (d.cnt == '0) begin
                        d.st   = EV_IDLE;
                        d.swap = 1'b1;
                    end else begin
                        d.st = EV_FETCH;
                    end
                end
            end
            EV_FETCH: begin
                case (q.ph)
                    2'd0: d.ph = 2'd1;
                    2'd1: begin
                        d.slots[q.fslot].lo = cap;
                        d.ph = 2'd2;
                    end
                    default: begin
                        d.slots[q.fslot].hi = cap;
                        d.ph = 2'd0;
                        if ((CW'(q.fslot) + CW'(1)) == q.cnt) begin
                            d.st   = EV_IDLE;
                            d.swap = 1'b1;
                        end else begin
                            d.fslot = q.fslot + SW'(1);
                        end
                    end
                endcase
            end
            default: ;
        endcase
        if (line_start) begin
            d.st   = EV_SCAN;
            d.idx  = '0;
            d.cnt  = '0;
            d.line = line_y;
            d.swap = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_idx    = q.idx;
    assign pat_addr  = {q.tile[q.fslot], (q.ph != 2'd0), q.row[q.fslot]};
    assign swap      = q.swap;
    assign new_slots = q.slots;
    assign new_cnt   = q.cnt;

    assert_cnt_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(SLOTS));

    assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (q.st == EV_SCAN && q.idx == '0 && q.cnt == '0));

    assert_swap_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.swap |=> !q.swap);

    assert_plane_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == EV_FETCH && q.ph == 2'd1) |->
            (pat_addr[3] && !$past(pat_addr[3]) &&
             $past(pat_addr[11:4]) == pat_addr[11:4]));

endmodule

// File: rtl/sprite_mux.sv
module sprite_mux
    import sprite_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  slot_t [SLOTS-1:0]          new_slots,
    input  logic [$clog2(SLOTS+1)-1:0] new_cnt,
    input  logic [7:0]                 pix_x,
    output logic [4:0]                 color,
    output logic                       opaque,
    output logic                       behind
);
    localparam int CW = $clog2(SLOTS+1);

    typedef struct packed {
        slot_t [SLOTS-1:0] act;
        logic [SLOTS-1:0]  valid;
        logic [4:0]        color;
        logic              opaque;
        logic              behind;
    } mx_t;

    mx_t q, d;

    logic [SLOTS-1:0][1:0] pix2;
    logic [SLOTS-1:0]      opq;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [8:0] dx;
        logic [2:0] col;
        assign dx      = {1'b0, pix_x} - {1'b0, q.act[k].x};
        assign col     = 3'd7 - dx[2:0];
        assign pix2[k] = {q.act[k].hi[col], q.act[k].lo[col]};
        assign opq[k]  = q.valid[k] && (dx < 9'd8) && (pix2[k] != 2'b00);
    end

    always_comb begin
        d = q;
        if (load) begin
            d.act = new_slots;
            for (int k = 0; k < SLOTS; k++) d.valid[k] = (CW'(k) < new_cnt);
        end
        d.color  = 5'd0;
        d.opaque = 1'b0;
        d.behind = 1'b0;
        // Walk from the back so the lowest slot is applied last and wins
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (opq[k]) begin
                d.color  = {1'b1, q.act[k].pal, pix2[k]};
                d.opaque = 1'b1;
                d.behind = q.act[k].behind;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign color  = q.color;
    assign opaque = q.opaque;
    assign behind = q.behind;

    assert_blank_when_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid == '0) |=> !q.opaque);

    assert_transparent_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.opaque |-> (q.color == 5'd0 && !q.behind));

    assert_color_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.opaque |-> (q.color[4] && q.color[1:0] != 2'b00));

endmodule

// File: rtl/sprite_renderer.sv
module sprite_renderer
    import sprite_pkg::*;
#(
    parameter int NUM_SPR = 64,
    parameter int SLOTS   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         oam_we,
    input  logic [$clog2(NUM_SPR*4)-1:0] oam_addr,
    input  logic [7:0]                   oam_wdata,
    input  logic                         line_start,
    input  logic [7:0]                   line_y,
    input  logic [7:0]                   pix_x,
    output logic [11:0]                  pat_addr,
    input  logic [7:0]                   pat_rdata,
    output logic [4:0]                   spr_color,
    output logic                         spr_opaque,
    output logic                         spr_behind
);
    localparam int IW = $clog2(NUM_SPR);
    localparam int CW = $clog2(SLOTS+1);

    logic [IW-1:0]     rd_idx;
    spr_rec_t          rec;
    logic              swap;
    slot_t [SLOTS-1:0] new_slots;
    logic [CW-1:0]     new_cnt;

    sprite_table #(.NUM_SPR(NUM_SPR)) u_table (
        .clk    (clk),
        .we     (oam_we),
        .waddr  (oam_addr),
        .wdata  (oam_wdata),
        .rd_idx (rd_idx),
        .rd_rec (rec)
    );

    sprite_eval #(.NUM_SPR(NUM_SPR), .SLOTS(SLOTS)) u_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .line_y     (line_y),
        .rec        (rec),
        .pat_rdata  (pat_rdata),
        .rd_idx     (rd_idx),
        .pat_addr   (pat_addr),
        .swap       (swap),
        .new_slots  (new_slots),
        .new_cnt    (new_cnt)
    );

    sprite_mux #(.SLOTS(SLOTS)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (swap),
        .new_slots (new_slots),
        .new_cnt   (new_cnt),
        .pix_x     (pix_x),
        .color     (spr_color),
        .opaque    (spr_opaque),
        .behind    (spr_behind)
    );

    assert_quiet_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !spr_opaque);

endmodule

// File: tb/sim_sprite_renderer.sv
module sim_sprite_renderer;
    localparam int CLK_PERIOD = 10;
    localparam int PREP_WAIT  = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        oam_we = 1'b0;
    logic [7:0]  oam_addr = '0;
    logic [7:0]  oam_wdata = '0;
    logic        line_start = 1'b0;
    logic [7:0]  line_y = '0;
    logic [7:0]  pix_x = '0;
    logic [11:0] pat_addr;
    logic [7:0]  pat_rdata = '0;
    logic [4:0]  spr_color;
    logic        spr_opaque;
    logic        spr_behind;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] sy [64];
    logic [7:0] st [64];
    logic [7:0] sa [64];
    logic [7:0] sx [64];
    int unsigned lcg = 32'd12345;

    always #(CLK_PERIOD/2) clk = ~clk;

    sprite_renderer u0 (
        .clk(clk), .rst_n(rst_n), .oam_we(oam_we), .oam_addr(oam_addr),
        .oam_wdata(oam_wdata), .line_start(line_start), .line_y(line_y),
        .pix_x(pix_x), .pat_addr(pat_addr), .pat_rdata(pat_rdata),
        .spr_color(spr_color), .spr_opaque(spr_opaque), .spr_behind(spr_behind)
    );

    function automatic logic [7:0] patf(input logic [11:0] a);
        logic [15:0] t;
        t = 16'(a) * 16'd73 + 16'(a >> 3) * 16'd29 + 16'd5;
        return t[7:0] ^ t[12:5];
    endfunction

    // Pattern memory: data one clock after the address (R5)
    always @(posedge clk) pat_rdata <= patf(pat_addr);

    function automatic int next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'(lcg >> 16);
    endfunction

    // Returns {behind, opaque, color[4:0]}
    function automatic logic [6:0] ref_px(input int line, input int x);
        int n = 0;
        logic [6:0] r = '0;
        for (int s = 0; s < 64; s++) begin
            int dy = line - int'(sy[s]);
            if (dy >= 0 && dy < 8 && n < 8) begin
                int dx = x - int'(sx[s]);
                n++;
                if (!r[5] && dx >= 0 && dx < 8) begin
                    int row = sa[s][7] ? 7 - dy : dy;
                    int col = sa[s][6] ? dx : 7 - dx;
                    logic [7:0] lo = patf({st[s], 1'b0, 3'(row)});
                    logic [7:0] hi = patf({st[s], 1'b1, 3'(row)});
                    logic [1:0] p = {hi[col], lo[col]};
                    if (p != 2'b00) r = {sa[s][5], 1'b1, 1'b1, sa[s][1:0], p};
                end
            end
        end
        return r;
    endfunction

    task automatic wr_byte(input int a, input logic [7:0] v);
        @(negedge clk);
        oam_we = 1'b1; oam_addr = 8'(a); oam_wdata = v;
        @(negedge clk);
        oam_we = 1'b0;
    endtask

    // R1: byte address = sprite*4 + field (0 Y, 1 tile, 2 attribute, 3 X)
    task automatic set_spr(input int s, input int y, input int t, input int at, input int x);
        sy[s] = 8'(y); st[s] = 8'(t); sa[s] = 8'(at); sx[s] = 8'(x);
        wr_byte(s*4 + 3, 8'(x));
        wr_byte(s*4 + 1, 8'(t));
        wr_byte(s*4 + 0, 8'(y));
        wr_byte(s*4 + 2, 8'(at));
    endtask

    task automatic park_all();
        for (int s = 0; s < 64; s++) set_spr(s, 240, s, 0, s);
    endtask

    task automatic start_line(input int l);
        @(negedge clk);
        line_start = 1'b1; line_y = 8'(l);
        @(negedge clk);
        line_start = 1'b0;
    endtask

    // R10: outputs for x are sampled one edge after x is presented
    task automatic check_px(input string tag, input int line, input int x);
        logic [6:0] exp_v, got;
        @(negedge clk);
        pix_x = 8'(x);
        @(negedge clk);
        exp_v = ref_px(line, x);
        got = {spr_behind, spr_opaque, spr_color};
        checks++;
        if (got !== exp_v) begin
            fails++;
            $display("FAIL %s line=%0d x=%0d got=%b expected=%b", tag, line, x, got, exp_v);
        end
    endtask

    task automatic sweep(input string tag, input int line);
        for (int x = 0; x < 256; x++) check_px(tag, line, x);
    endtask

    task automatic prep_and_sweep(input string tag, input int line);
        start_line(line);
        repeat (PREP_WAIT) @(negedge clk);
        sweep(tag, line);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired got=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 64; s++) begin sy[s] = 8'd240; st[s] = '0; sa[s] = '0; sx[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: nothing active after reset
        for (int x = 0; x < 16; x++) check_px("R11 reset", 255, x * 16);

        park_all();
        // Scene 1: dense random sprites, heavy overlap and over-full lines
        for (int s = 0; s < 64; s++) begin
            int r1 = next_rand();
            int r2 = next_rand();
            set_spr(s, 30 + (r1 % 40), r2 % 256, (r1 >> 8) % 256, (r2 >> 8) % 256);
        end
        for (int l = 26; l < 80; l += 4)
            prep_and_sweep("R1/R2/R3/R4/R5/R6/R7/R8/R9/R10", l);

        // R11: during preparation of line 51 the old set (line 50) still drives pixels
        prep_and_sweep("R11 before", 50);
        start_line(51);
        for (int i = 0; i < 28; i++) check_px("R11 old set kept", 50, i * 9);
        repeat (PREP_WAIT) @(negedge clk);
        for (int i = 0; i < 64; i++) check_px("R11 new set", 51, i * 4);

        // R12: restart mid-scan
        start_line(40);
        repeat (20) @(negedge clk);
        start_line(63);
        repeat (PREP_WAIT) @(negedge clk);
        sweep("R12 restart", 63);

        // Scene 2: no wrap at the bottom/right edges (R2, R4), flips (R6, R7)
        park_all();
        set_spr(0, 252, 17, 8'h41, 250);
        set_spr(1, 250, 90, 8'h82, 3);
        set_spr(2, 248, 33, 8'hE3, 120);
        set_spr(3, 248, 33, 8'h03, 130);
        prep_and_sweep("R2 wrap", 2);
        prep_and_sweep("R2/R4/R7 edge", 255);
        prep_and_sweep("R6/R7 flips", 252);

        // Scene 3: ten sprites on one line, side by side (R3)
        park_all();
        for (int s = 0; s < 10; s++) set_spr(s, 100, s + 3, s % 4, s * 8);
        prep_and_sweep("R3 limit", 103);

        // Scene 4: stacked at one column, ordering by index (R8, R9)
        park_all();
        for (int s = 0; s < 8; s++) set_spr(s, 100, s * 11 + 1, (s % 4) | ((s % 2) << 5), 60 + s);
        prep_and_sweep("R8/R9 order", 100);
        prep_and_sweep("R8/R9 order", 107);

        // Empty line after a populated one (R11)
        prep_and_sweep("R11 empty", 180);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule